// File: doc/BRIEF.md
# Packetized OTP Read Controller

This block is a read-only front end for a one-time-programmable word array whose contents form a chain of variable-length packets. Every packet opens with a 32-bit header word. The header carries the payload length, and the payload words follow it directly. The chain starts at word 0. A header whose length field is zero terminates the chain.

Software uses a small word-wide register bus. It places a word address in the mode register and sets the command bit in the control register. It then polls the busy bit in the status register. The controller walks the headers from word 0 until it finds the packet whose span holds the requested address. It copies that packet's header and the first `DEPTH` payload words into holding registers. The result is always the whole containing packet, never the single addressed word. Software then reads the header from its own register and streams the payload through a data register. Each read of the data register advances an internal pointer.

A test load port writes the backing array directly. The array is an ordinary synthesizable memory.

Top module: `pkt_otp_reader`

## Requirements
- R1: The mode register (offset 0x04) stores a full 32-bit write and reads it back. Bits 31:16 hold the word address used by the next read command.
- R2: Writing a word with bit 6 set to the control register (offset 0x00) starts a packet fetch. The control register always reads as zero.
- R3: Status register (offset 0x0C) bit 6 reads 1 from the cycle after the command until the fetch is complete, and then returns to 0.
- R4: The walk visits headers in order, one per cycle. The next packet starts at the current start plus the header's bits 15:8 plus 2. After a hit, one payload word is copied per cycle, up to min(length+1, DEPTH) words. The busy time equals the headers visited plus the words copied.
- R5: Any address from a packet's first word up to the word before the next packet's start loads that packet. Its header then reads at offset 0x20.
- R6: Each read of the data register (offset 0x24) returns the payload word at the pointer and then increments the pointer. After a fetch, the pointer starts at the first payload word.
- R7: The pointer register (offset 0x08) reads back the pointer. Writing 0 to it rewinds the stream to the first payload word.
- R8: A data read at a pointer at or beyond the payload length, or at or beyond DEPTH, returns zero.
- R9: A request that reaches a zero-length header, or a header position at or beyond the array size, completes with the header register at zero. Data reads then return zero.
- R10: A read command issued while busy is ignored. The running fetch keeps its latched address and its timing.
- R11: The load port writes the given word of the backing array in one cycle.
- R12: After reset, the header, status, pointer and mode registers all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data valid the following cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ld_en | input | 1 | Test load write enable |
| ld_addr | input | $clog2(WORDS) | Test load word index |
| ld_data | input | 32 | Test load word |

## Verification
The bench builds the block with a 32-word array and a 4-word holding buffer. At that size, a 6-word payload overflows the buffer, so the zero return past DEPTH can be observed. The small array also lets a chain run off the array's end without a terminator, which tests the array-size bound. Each busy interval is compared against a walk over the bench's own copy of the image, so the one-cycle-per-header and one-cycle-per-word timing is checked for the first, middle and last words of several packets.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int PW = 17;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_MODE   = 8'h04;
  localparam logic [7:0] OFS_PTR    = 8'h08;
  localparam logic [7:0] OFS_STATUS = 8'h0C;
  localparam logic [7:0] OFS_HDR    = 8'h20;
  localparam logic [7:0] OFS_DATA   = 8'h24;

  localparam int CMD_BIT  = 6;
  localparam int BUSY_BIT = 6;

  typedef enum logic [1:0] {F_IDLE, F_WALK, F_COPY} fetch_st_t;

  function automatic logic [7:0] hdr_size(input logic [31:0] h);
    return h[15:8];
  endfunction

  function automatic logic [PW-1:0] next_start(input logic [PW-1:0] cur,
                                                input logic [7:0] sz);
    return cur + PW'(sz) + PW'(2);
  endfunction

  function automatic int copy_words(input int plen, input int depth);
    return (plen > depth) ? depth : plen;
  endfunction

endpackage

// File: rtl/otp_array.sv
module otp_array #(
  parameter int WORDS = 1024,
  localparam int AW = $clog2(WORDS)
) (
  input  logic                  clk,
  input  logic                  ld_en,
  input  logic [AW-1:0]         ld_addr,
  input  logic [31:0]           ld_data,
  input  logic [otp_pkg::PW-1:0] rd_addr,
  output logic [31:0]           rd_data
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
  end

  always_comb begin
    if (rd_addr < otp_pkg::PW'(WORDS)) rd_data = mem[rd_addr[AW-1:0]];
    else                               rd_data = '0;
  end
endmodule

// File: rtl/otp_fetch.sv
module otp_fetch
  import otp_pkg::*;
#(
  parameter int WORDS = 1024,
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [15:0]   target,
  input  logic [31:0]   rd_data,
  output logic [PW-1:0] rd_addr,
  output logic          busy,
  output logic          hit,
  output logic          miss,
  output logic [31:0]   hdr_val,
  output logic [8:0]    plen_val,
  output logic          buf_we,
  output logic [IW-1:0] buf_idx,
  output logic [31:0]   buf_data,
  output logic          done,
  output logic [15:0]   tgt_o
);
  fetch_st_t     st;
  logic [PW-1:0] cur;
  logic [15:0]   tgt;
  logic [CW-1:0] ncopy, cnt;

  logic [7:0]    sz;
  logic [PW-1:0] nxt;
  logic          at_end, last_copy;

  always_comb begin
    sz        = hdr_size(rd_data);
    nxt       = next_start(cur, sz);
    at_end    = (cur >= PW'(WORDS)) || (sz == 8'd0);
    hit       = (st == F_WALK) && !at_end && ({1'b0, tgt} < nxt);
    miss      = (st == F_WALK) && at_end;
    rd_addr   = (st == F_COPY) ? cur + PW'(cnt) + PW'(1) : cur;
    hdr_val   = hit ? rd_data : 32'd0;
    plen_val  = hit ? ({1'b0, sz} + 9'd1) : 9'd0;
    buf_we    = (st == F_COPY);
    buf_idx   = cnt[IW-1:0];
    buf_data  = rd_data;
    last_copy = (st == F_COPY) && (cnt == ncopy - CW'(1));
    done      = miss || last_copy;
    busy      = (st != F_IDLE);
    tgt_o     = tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= F_IDLE;
      cur   <= '0;
      tgt   <= '0;
      ncopy <= '0;
      cnt   <= '0;
    end else begin
      case (st)
        F_IDLE: if (start) begin
          tgt <= target;
          cur <= '0;
          st  <= F_WALK;
        end
        F_WALK: begin
          if (miss) st <= F_IDLE;
          else if (hit) begin
            st    <= F_COPY;
            cnt   <= '0;
            ncopy <= CW'(copy_words(int'(plen_val), DEPTH));
          end else cur <= nxt;
        end
        F_COPY: begin
          if (last_copy) st <= F_IDLE;
          else           cnt <= cnt + CW'(1);
        end
        default: st <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/otp_regs.sv
module otp_regs
  import otp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          busy,
  input  logic          hit,
  input  logic          miss,
  input  logic [31:0]   hdr_val,
  input  logic [8:0]    plen_val,
  input  logic          buf_we,
  input  logic [IW-1:0] buf_idx,
  input  logic [31:0]   buf_data,
  output logic          start,
  output logic [15:0]   target,
  output logic [8:0]    ptr_o,
  output logic [31:0]   hdr_o,
  output logic          data_rd,
  output logic          ptr_wr
);
  logic [31:0] mode_q, hdr_q;
  logic [8:0]  ptr_q, plen_q;
  logic [31:0] buf_q [DEPTH];
  logic [31:0] data_word, rd_mux;
  logic        in_range, load;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_buf
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               buf_q[gi] <= '0;
        else if (buf_we && buf_idx == IW'(gi))    buf_q[gi] <= buf_data;
      end
    end
  endgenerate

  always_comb begin
    start     = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[CMD_BIT];
    ptr_wr    = bus_wr && (bus_addr == OFS_PTR);
    data_rd   = bus_rd && (bus_addr == OFS_DATA);
    load      = hit || miss;
    target    = mode_q[31:16];
    ptr_o     = ptr_q;
    hdr_o     = hdr_q;
    in_range  = (ptr_q < plen_q) && (ptr_q < 9'(DEPTH));
    data_word = in_range ? buf_q[ptr_q[IW-1:0]] : 32'd0;
    case (bus_addr)
      OFS_MODE:   rd_mux = mode_q;
      OFS_PTR:    rd_mux = {23'd0, ptr_q};
      OFS_STATUS: rd_mux = 32'(busy) << BUSY_BIT;
      OFS_HDR:    rd_mux = hdr_q;
      OFS_DATA:   rd_mux = data_word;
      default:    rd_mux = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= '0;
      hdr_q     <= '0;
      plen_q    <= '0;
      ptr_q     <= '0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == OFS_MODE) mode_q <= bus_wdata;
      if (load) begin
        hdr_q  <= hdr_val;
        plen_q <= plen_val;
      end
      if (load)                         ptr_q <= '0;
      else if (ptr_wr)                  ptr_q <= bus_wdata[8:0];
      else if (data_rd && ptr_q != '1)  ptr_q <= ptr_q + 9'd1;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/pkt_otp_reader.sv
module pkt_otp_reader #(
  parameter int WORDS = 1024,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(WORDS),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [31:0]   ld_data
);
  logic [otp_pkg::PW-1:0] arr_addr;
  logic [31:0]   arr_data, hdr_val, buf_data, hdr_q;
  logic          busy, hit, miss, buf_we, done, start, data_rd, ptr_wr;
  logic [8:0]    plen_val, ptr;
  logic [IW-1:0] buf_idx;
  logic [15:0]   target, tgt;

  otp_array #(.WORDS(WORDS)) u_array (
    .clk(clk), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(arr_addr), .rd_data(arr_data)
  );

  otp_fetch #(.WORDS(WORDS), .DEPTH(DEPTH)) u_fetch (
    .clk(clk), .rst_n(rst_n), .start(start), .target(target),
    .rd_data(arr_data), .rd_addr(arr_addr), .busy(busy), .hit(hit),
    .miss(miss), .hdr_val(hdr_val), .plen_val(plen_val), .buf_we(buf_we),
    .buf_idx(buf_idx), .buf_data(buf_data), .done(done), .tgt_o(tgt)
  );

  otp_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .hit(hit), .miss(miss), .hdr_val(hdr_val),
    .plen_val(plen_val), .buf_we(buf_we), .buf_idx(buf_idx),
    .buf_data(buf_data), .start(start), .target(target), .ptr_o(ptr),
    .hdr_o(hdr_q), .data_rd(data_rd), .ptr_wr(ptr_wr)
  );
endmodule

// File: rtl/pkt_otp_reader_chk.sv
module pkt_otp_reader_chk #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          start,
  input logic          done,
  input logic          hit,
  input logic          miss,
  input logic [31:0]   hdr_q,
  input logic [8:0]    ptr,
  input logic [15:0]   tgt,
  input logic          data_rd,
  input logic          ptr_wr,
  input logic          buf_we,
  input logic [IW-1:0] buf_idx
);
  a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r3_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  a_r3_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  a_r10_target_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(tgt));

  a_r4_copy_follows_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (buf_we && buf_idx == '0));

  a_r9_miss_zero_header: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (hdr_q == 32'd0));

  a_r6_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !ptr_wr && !hit && !miss && ptr != 9'h1FF)
      |=> (ptr == $past(ptr) + 9'd1));
endmodule

bind pkt_otp_reader pkt_otp_reader_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start(start), .done(done),
  .hit(hit), .miss(miss), .hdr_q(hdr_q), .ptr(ptr), .tgt(tgt),
  .data_rd(data_rd), .ptr_wr(ptr_wr), .buf_we(buf_we), .buf_idx(buf_idx)
);

// File: tb/pkt_otp_reader_tb.sv
module pkt_otp_reader_tb;
  localparam int WORDS = 32;
  localparam int DEPTH = 4;
  localparam int AW = $clog2(WORDS);

  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0, bus_rd = 0, ld_en = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, ld_data = 0;
  logic [AW-1:0] ld_addr = 0;
  logic [31:0] bus_rdata;

  int checks = 0, errors = 0;
  logic [31:0] img [WORDS];

  always #5 clk = ~clk;

  pkt_otp_reader #(.WORDS(WORDS), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic put(input int i, input logic [31:0] w);
    img[i] = w;
    ld_en = 1; ld_addr = AW'(i); ld_data = w;
    @(negedge clk);
    ld_en = 0;
  endtask

  function automatic logic [31:0] mk_hdr(input int k, input int sz);
    return {16'h5A00 + 16'(k), 8'(sz), 8'h3C};
  endfunction

  // R11: image written through the load port
  task automatic load_image();
    for (int i = 0; i < WORDS; i++) put(i, 32'h0BAD_0000 + 32'(i));
    put(0, mk_hdr(0, 2));
    for (int j = 0; j < 3; j++) put(1 + j, 32'h7000_0000 + 32'(j));
    put(4, mk_hdr(1, 5));
    for (int j = 0; j < 6; j++) put(5 + j, 32'h7000_0100 + 32'(j));
    put(11, mk_hdr(2, 1));
    for (int j = 0; j < 2; j++) put(12 + j, 32'h7000_0200 + 32'(j));
    put(14, 32'hDEAD_00EF);
  endtask

  // Bench model: walk the mirror image
  task automatic model(input int addr, output bit found, output int pstart,
                       output int sz, output int visits);
    int pos = 0;
    found = 0; pstart = 0; sz = 0; visits = 0;
    while (1) begin
      int s;
      visits++;
      if (pos >= WORDS) return;
      s = int'(img[pos][15:8]);
      if (s == 0) return;
      if (addr < pos + s + 2) begin
        found = 1; pstart = pos; sz = s; return;
      end
      pos = pos + s + 2;
    end
  endtask

  task automatic count_busy(output int n);
    logic [31:0] d;
    n = 0;
    for (int i = 0; i < 200; i++) begin
      rd(8'h0C, d);
      if (!d[6]) break;
      n++;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h20, d); check("R12 header", d, 0);
    rd(8'h0C, d); check("R12 status", d, 0);
    rd(8'h08, d); check("R12 pointer", d, 0);
    rd(8'h04, d); check("R12 mode", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(8'h04, 32'hABCD_1234);
    rd(8'h04, d); check("R1 mode readback", d, 32'hABCD_1234);
    rd(8'h00, d); check("R2 control reads zero", d, 0);
  endtask

  task automatic t_fetch(input int addr);
    bit f; int ps, sz, vis, n, pl, exp_busy;
    logic [31:0] d;
    model(addr, f, ps, sz, vis);
    pl = f ? sz + 1 : 0;
    exp_busy = vis + (pl > DEPTH ? DEPTH : pl);
    wr(8'h04, 32'(addr) << 16);
    wr(8'h00, 32'h40);
    count_busy(n);
    check($sformatf("R4 busy cycles addr %0d", addr), 32'(n), 32'(exp_busy));
    rd(8'h0C, d); check("R3 status clear", d, 0);
    rd(8'h20, d);
    if (f) check($sformatf("R5 header addr %0d", addr), d, img[ps]);
    else   check($sformatf("R9 header zero addr %0d", addr), d, 0);
    rd(8'h08, d); check("R6 pointer at start", d, 0);
    for (int j = 0; j <= DEPTH + 1; j++) begin
      rd(8'h24, d);
      if (j < pl && j < DEPTH)
        check($sformatf("R6 payload %0d addr %0d", j, addr), d, img[ps + 1 + j]);
      else
        check($sformatf("R8 zero past end %0d addr %0d", j, addr), d, 0);
    end
  endtask

  task automatic t_rewind();
    logic [31:0] d;
    t_fetch(4);
    wr(8'h08, 0);
    rd(8'h08, d); check("R7 pointer rewound", d, 0);
    rd(8'h24, d); check("R7 first word again", d, img[5]);
    rd(8'h24, d); check("R6 second word", d, img[6]);
    rd(8'h08, d); check("R7 pointer readback", d, 2);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] d; int n;
    wr(8'h04, 32'd0 << 16);
    wr(8'h00, 32'h40);
    wr(8'h04, 32'd11 << 16);
    wr(8'h00, 32'h40);
    count_busy(n);
    check("R10 busy unaffected", 32'(n), 2);
    rd(8'h20, d); check("R10 first request kept", d, img[0]);
    rd(8'h24, d); check("R10 payload of first request", d, img[1]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    load_image();
    t_fetch(0);
    t_fetch(3);
    t_fetch(4);
    t_fetch(10);
    t_fetch(11);
    t_fetch(13);
    t_fetch(14);
    t_fetch(200);
    t_rewind();
    t_busy_ignore();
    t_fetch(11);
    // R9: chain runs off the array end with no terminator
    put(14, mk_hdr(3, 17));
    t_fetch(20);
    t_fetch(33);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule